// File: doc/BRIEF.md
# Test Packet Multicast Wrapper

This unit sits beside the routing logic of a four-port switch and takes over the input stream whenever a packet is a multicast test packet. A multicast test packet carries, after its header and its control flit, a route list. The list holds one entry per switch, and each entry gives a switch address and the output ports that switch must copy the packet to. The unit scans that list until it finds the entry for its own address. It then sends the whole packet unchanged to every port in that entry. All copies move in lockstep, so no arbitration and no routing table are involved. Any other packet goes straight on to the normal routing path with no added cycle.

While scanning, the unit keeps the flits it has seen so far in a small buffer, because the header, the control flit and the earlier route entries must reach the outputs ahead of the rest. Some packets cannot be delivered: the list has no entry for this switch, the matching entry selects no port that may take copies, the list is longer than the buffer, or the packet ends early. Such a packet is consumed and discarded, and the unit raises a one-cycle error pulse. A parameter mask sets which output ports may take multicast copies at all.

Top module: `mcast_test_wrapper`

## Requirements
- R1: A packet whose header flit does not have both bit FLIT_W-1 (test flag) and bit FLIT_W-2 (multicast flag) set is passed to the normal path. norm_valid follows in_valid in the same cycle, in_ready follows norm_ready, and data and last pass unchanged. rlb_bypass is low and no mc_valid bit is set.
- R2: From the cycle a multicast test header is presented until that packet's last flit is consumed, rlb_bypass is high and norm_valid is low.
- R3: The route list starts at the third flit. Each entry has bit FLIT_W-1 = 0, the switch address in bits [ADDR_W+3:4] and the port mask in bits [3:0], where bit p selects output port p. On a match, every flit of the packet is sent in order and unchanged, with its last flag, to exactly the ports in (mask AND MC_EN). This covers the header, the control flit, all route entries and the data.
- R4: The copies move in lockstep. A selected port sees valid only in a cycle when all selected ports are ready, and the input stalls while any selected port is not ready.
- R5: Only the first entry whose address matches own_addr is used. Later entries with the same address are forwarded as ordinary flits.
- R6: A route entry with bit FLIT_W-1 = 1 is an end marker. Reaching it with no match drops the whole packet: no output sees any flit, the input is consumed to its last flit, and drop_err pulses for one cycle.
- R7: Ports whose MC_EN bit is 0 never receive a copy. A matching entry whose mask has no enabled port is dropped as in R6.
- R8: If none of the first MAX_ROUTE route entries is an end marker or a match, the packet is dropped as in R6.
- R9: A multicast test packet that ends before a match or an end marker is dropped as in R6. This includes a packet that ends at its header or at its control flit.
- R10: After reset, mc_valid, norm_valid, rlb_bypass and drop_err are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| own_addr | input | ADDR_W | This switch's address |
| in_valid | input | 1 | Input flit valid |
| in_ready | output | 1 | Input flit accepted |
| in_data | input | FLIT_W | Input flit |
| in_last | input | 1 | Input flit is the last of its packet |
| norm_valid | output | 1 | Flit valid toward normal routing logic |
| norm_ready | input | 1 | Normal routing logic ready |
| norm_data | output | FLIT_W | Flit toward normal routing logic |
| norm_last | output | 1 | Last flag toward normal routing logic |
| rlb_bypass | output | 1 | High while this unit owns the input stream |
| mc_valid | output | 4 | Per-port copy valid |
| mc_ready | input | 4 | Per-port copy ready |
| mc_data | output | 4 x FLIT_W | Per-port copy flit |
| mc_last | output | 4 | Per-port copy last flag |
| drop_err | output | 1 | One-cycle pulse when a multicast test packet is discarded |

## Verification
The hardest case to reach is a replay of buffered flits that stalls partway through, because one selected port is held not ready while the input is already blocked behind the buffer. A directed case holds a single selected port low for many cycles, checks that no port received anything and that the input is stalled, and then releases it. Route lists that end exactly at the buffer limit, or one entry beyond it, are built on purpose. Random packets with random route lists, random gaps and random per-port readiness then mix drops, passes and matches back to back.

// File: rtl/mcw_pkg.sv
package mcw_pkg;

    localparam int NPORT = 4;

    typedef logic [NPORT-1:0] pmask_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PASS,
        S_COLLECT,
        S_REPLAY,
        S_STREAM,
        S_DROP
    } mcw_state_e;

    typedef enum logic {
        K_NORMAL,
        K_MCTEST
    } pkt_kind_e;

    typedef enum logic [1:0] {
        D_KEEP,
        D_HIT,
        D_DROP
    } col_dec_e;

    typedef struct packed {
        logic   end_mk;
        logic   hit;
        pmask_t mask;
    } route_dec_t;

    // every selected port ready at once
    function automatic logic lockstep_ok(pmask_t sel, pmask_t rdy);
        return &(rdy | ~sel);
    endfunction

    function automatic pmask_t restrict_mask(pmask_t m, pmask_t en);
        return m & en;
    endfunction

endpackage

// File: rtl/mcw_hdr_classify.sv
module mcw_hdr_classify
    import mcw_pkg::*;
(
    input  logic [1:0] tag,
    output pkt_kind_e  kind
);
    // tag[1] test flag, tag[0] multicast flag
    always_comb begin
        kind = (tag == 2'b11) ? K_MCTEST : K_NORMAL;
    end
endmodule

// File: rtl/mcw_route_decode.sv
module mcw_route_decode
    import mcw_pkg::*;
#(
    parameter int     ADDR_W = 6,
    parameter pmask_t MC_EN  = '1
) (
    input  logic                      end_bit,
    input  logic [ADDR_W+NPORT-1:0]   entry,
    input  logic [ADDR_W-1:0]         own_addr,
    output route_dec_t                dec
);
    localparam int ADDR_LO = NPORT;
    localparam int ADDR_HI = NPORT + ADDR_W - 1;

    always_comb begin
        dec.end_mk = end_bit;
        dec.hit    = !end_bit && (entry[ADDR_HI:ADDR_LO] == own_addr);
        dec.mask   = restrict_mask(entry[NPORT-1:0], MC_EN);
    end
endmodule

// File: rtl/mcw_flit_buf.sv
module mcw_flit_buf #(
    parameter int WORD_W = 33,
    parameter int DEPTH  = 10,
    localparam int IDX_W = $clog2(DEPTH + 1),
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_word,
    output logic [IDX_W-1:0]  count,
    output logic              rd_last_slot
);
    logic [WORD_W-1:0] mem [DEPTH];
    logic [IDX_W-1:0]  cnt_q;
    logic [IDX_W-1:0]  rd_q;
    logic              do_wr;

    assign do_wr = wr_en && !clr && (cnt_q < IDX_W'(DEPTH));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            rd_q  <= '0;
        end else if (clr) begin
            cnt_q <= '0;
            rd_q  <= '0;
        end else begin
            if (do_wr) cnt_q <= cnt_q + IDX_W'(1);
            if (rd_en) rd_q  <= rd_q + IDX_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (do_wr) mem[cnt_q[PTR_W-1:0]] <= wr_word;
    end

    assign rd_word      = mem[rd_q[PTR_W-1:0]];
    assign count        = cnt_q;
    assign rd_last_slot = ((rd_q + IDX_W'(1)) == cnt_q);
endmodule

// File: rtl/mcw_fanout.sv
module mcw_fanout
    import mcw_pkg::*;
#(
    parameter int FLIT_W = 32
) (
    input  pmask_t                       sel,
    input  logic                         src_valid,
    input  logic [FLIT_W-1:0]            src_data,
    input  logic                         src_last,
    input  pmask_t                       port_ready,
    output pmask_t                       port_valid,
    output logic [NPORT-1:0][FLIT_W-1:0] port_data,
    output pmask_t                       port_last,
    output logic                         fire
);
    assign fire = src_valid && (sel != '0) && lockstep_ok(sel, port_ready);

    generate
        for (genvar p = 0; p < NPORT; p++) begin : g_port
            assign port_valid[p] = fire && sel[p];
            assign port_data[p]  = src_data;
            assign port_last[p]  = src_last;
        end
    endgenerate
endmodule

// File: rtl/mcast_test_wrapper.sv
module mcast_test_wrapper
    import mcw_pkg::*;
#(
    parameter int     FLIT_W    = 32,
    parameter int     ADDR_W    = 6,
    parameter int     MAX_ROUTE = 8,
    parameter pmask_t MC_EN     = 4'b1111
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [ADDR_W-1:0]            own_addr,
    input  logic                         in_valid,
    output logic                         in_ready,
    input  logic [FLIT_W-1:0]            in_data,
    input  logic                         in_last,
    output logic                         norm_valid,
    input  logic                         norm_ready,
    output logic [FLIT_W-1:0]            norm_data,
    output logic                         norm_last,
    output logic                         rlb_bypass,
    output logic [NPORT-1:0]             mc_valid,
    input  logic [NPORT-1:0]             mc_ready,
    output logic [NPORT-1:0][FLIT_W-1:0] mc_data,
    output logic [NPORT-1:0]             mc_last,
    output logic                         drop_err
);
    localparam int DEPTH = MAX_ROUTE + 2;          // header + control + entries
    localparam int IDX_W = $clog2(DEPTH + 1);

    mcw_state_e state_q, state_d;
    pmask_t     sel_q, sel_d;
    logic       err_q, err_d;

    pkt_kind_e  kind;
    route_dec_t rdec;
    col_dec_e   cdec;

    logic              buf_wr, buf_rd, buf_clr, buf_rd_last_slot;
    logic [FLIT_W:0]   buf_rd_word;
    logic [IDX_W-1:0]  buf_count;

    logic              src_valid, src_last, fan_fire;
    logic [FLIT_W-1:0] src_data;
    pmask_t            sel_act;

    mcw_hdr_classify u_cls (
        .tag  (in_data[FLIT_W-1 -: 2]),
        .kind (kind)
    );

    mcw_route_decode #(.ADDR_W(ADDR_W), .MC_EN(MC_EN)) u_dec (
        .end_bit  (in_data[FLIT_W-1]),
        .entry    (in_data[ADDR_W+NPORT-1:0]),
        .own_addr (own_addr),
        .dec      (rdec)
    );

    mcw_flit_buf #(.WORD_W(FLIT_W + 1), .DEPTH(DEPTH)) u_buf (
        .clk          (clk),
        .rst          (rst),
        .clr          (buf_clr),
        .wr_en        (buf_wr),
        .wr_word      ({in_last, in_data}),
        .rd_en        (buf_rd),
        .rd_word      (buf_rd_word),
        .count        (buf_count),
        .rd_last_slot (buf_rd_last_slot)
    );

    // source of the copies: buffer during replay, live input afterwards
    always_comb begin
        sel_act   = '0;
        src_valid = 1'b0;
        src_data  = in_data;
        src_last  = in_last;
        case (state_q)
            S_REPLAY: begin
                sel_act   = sel_q;
                src_valid = 1'b1;
                src_data  = buf_rd_word[FLIT_W-1:0];
                src_last  = buf_rd_word[FLIT_W];
            end
            S_STREAM: begin
                sel_act   = sel_q;
                src_valid = in_valid;
            end
            default: ;
        endcase
    end

    mcw_fanout #(.FLIT_W(FLIT_W)) u_fan (
        .sel        (sel_act),
        .src_valid  (src_valid),
        .src_data   (src_data),
        .src_last   (src_last),
        .port_ready (mc_ready),
        .port_valid (mc_valid),
        .port_data  (mc_data),
        .port_last  (mc_last),
        .fire       (fan_fire)
    );

    // decision for the flit being collected (index = buf_count)
    always_comb begin
        cdec = D_KEEP;
        if (buf_count == IDX_W'(1)) begin
            cdec = in_last ? D_DROP : D_KEEP;
        end else if (rdec.end_mk) begin
            cdec = D_DROP;
        end else if (rdec.hit) begin
            cdec = (rdec.mask != '0) ? D_HIT : D_DROP;
        end else if (in_last || (buf_count == IDX_W'(DEPTH - 1))) begin
            cdec = D_DROP;
        end
    end

    always_comb begin
        state_d    = state_q;
        sel_d      = sel_q;
        err_d      = 1'b0;
        in_ready   = 1'b0;
        norm_valid = 1'b0;
        buf_wr     = 1'b0;
        buf_rd     = 1'b0;
        buf_clr    = 1'b0;
        rlb_bypass = 1'b1;
        unique case (state_q)
            S_IDLE: begin
                if (in_valid && kind == K_MCTEST) begin
                    in_ready = 1'b1;
                    if (in_last) begin
                        err_d = 1'b1;
                    end else begin
                        buf_wr  = 1'b1;
                        state_d = S_COLLECT;
                    end
                end else begin
                    rlb_bypass = 1'b0;
                    norm_valid = in_valid;
                    in_ready   = norm_ready;
                    if (in_valid && norm_ready && !in_last) state_d = S_PASS;
                end
            end
            S_PASS: begin
                rlb_bypass = 1'b0;
                norm_valid = in_valid;
                in_ready   = norm_ready;
                if (in_valid && norm_ready && in_last) state_d = S_IDLE;
            end
            S_COLLECT: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    case (cdec)
                        D_KEEP: buf_wr = 1'b1;
                        D_HIT: begin
                            buf_wr  = 1'b1;
                            sel_d   = rdec.mask;
                            state_d = S_REPLAY;
                        end
                        default: begin
                            buf_clr = 1'b1;
                            err_d   = 1'b1;
                            state_d = in_last ? S_IDLE : S_DROP;
                        end
                    endcase
                end
            end
            S_REPLAY: begin
                if (fan_fire) begin
                    buf_rd = 1'b1;
                    if (buf_rd_last_slot) begin
                        buf_clr = 1'b1;
                        state_d = src_last ? S_IDLE : S_STREAM;
                    end
                end
            end
            S_STREAM: begin
                in_ready = lockstep_ok(sel_q, mc_ready);
                if (fan_fire && in_last) state_d = S_IDLE;
            end
            S_DROP: begin
                in_ready = 1'b1;
                if (in_valid && in_last) state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            sel_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            sel_q   <= sel_d;
            err_q   <= err_d;
        end
    end

    assign norm_data = in_data;
    assign norm_last = in_last;
    assign drop_err  = err_q;
endmodule

// File: rtl/mcast_test_wrapper_chk.sv
module mcast_test_wrapper_chk
    import mcw_pkg::*;
#(
    parameter int     FLIT_W = 32,
    parameter pmask_t MC_EN  = '1
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         in_valid,
    input logic                         in_ready,
    input logic                         norm_valid,
    input logic                         rlb_bypass,
    input logic                         drop_err,
    input logic [NPORT-1:0]             mc_valid,
    input logic [NPORT-1:0]             mc_ready,
    input logic [NPORT-1:0][FLIT_W-1:0] mc_data
);
    // R1: the normal path and the copy path never run together
    assert_norm_excl_R1: assert property (@(posedge clk) disable iff (rst)
        norm_valid |-> (!rlb_bypass && mc_valid == '0));

    // R2: copies only appear while the normal logic is bypassed
    assert_bypass_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (mc_valid != '0) |-> rlb_bypass);

    // R7: disabled ports stay silent
    assert_en_only_R7: assert property (@(posedge clk) disable iff (rst)
        (mc_valid & ~MC_EN) == '0);

    // R6: an error pulse follows a consumed input flit
    assert_err_after_accept_R6: assert property (@(posedge clk) disable iff (rst)
        drop_err |-> $past(in_valid && in_ready));

    generate
        for (genvar p = 0; p < NPORT; p++) begin : g_chk
            // R4: a copy is offered only to a ready port
            assert_lockstep_R4: assert property (@(posedge clk) disable iff (rst)
                mc_valid[p] |-> mc_ready[p]);
            if (p > 0) begin : g_same
                // R3: all simultaneous copies carry the same flit
                assert_same_data_R3: assert property (@(posedge clk) disable iff (rst)
                    (mc_valid[p] && mc_valid[0]) |-> (mc_data[p] == mc_data[0]));
            end
        end
    endgenerate
endmodule

bind mcast_test_wrapper mcast_test_wrapper_chk #(.FLIT_W(FLIT_W), .MC_EN(MC_EN)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .norm_valid (norm_valid),
    .rlb_bypass (rlb_bypass),
    .drop_err   (drop_err),
    .mc_valid   (mc_valid),
    .mc_ready   (mc_ready),
    .mc_data    (mc_data)
);

// File: tb/tb_mcast_test_wrapper.sv
`timescale 1ns/1ps
module tb_mcast_test_wrapper;
    localparam int FW = 32;
    localparam int AW = 6;
    localparam int MAXR = 4;
    localparam logic [3:0] EN = 4'b1011;
    localparam logic [5:0] OWN = 6'h15;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0, in_ready, in_last = 1'b0;
    logic [FW-1:0] in_data = '0;
    logic norm_valid, norm_ready = 1'b1, norm_last, rlb_bypass, drop_err;
    logic [FW-1:0] norm_data;
    logic [3:0] mc_valid, mc_ready = 4'hF, mc_last;
    logic [3:0][FW-1:0] mc_data;

    always #2.5 clk = ~clk;

    mcast_test_wrapper #(.FLIT_W(FW), .ADDR_W(AW), .MAX_ROUTE(MAXR), .MC_EN(EN)) dut (
        .clk(clk), .rst(rst), .own_addr(OWN),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
        .norm_valid(norm_valid), .norm_ready(norm_ready), .norm_data(norm_data), .norm_last(norm_last),
        .rlb_bypass(rlb_bypass),
        .mc_valid(mc_valid), .mc_ready(mc_ready), .mc_data(mc_data), .mc_last(mc_last),
        .drop_err(drop_err)
    );

    int n_checks = 0, n_errs = 0;
    bit done = 0;
    int ready_mode = 0;
    logic [32:0] pkt[$];
    logic [32:0] exp_q[5][$];
    logic [32:0] got_q[5][$];
    int exp_err = 0, got_err = 0;

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] f_hdr(bit t, bit m);
        return {t, m, 30'($urandom)};
    endfunction
    function automatic logic [31:0] f_ent(logic [5:0] a, logic [3:0] mk);
        return {1'b0, 21'($urandom), a, mk};
    endfunction
    function automatic logic [31:0] f_end();
        return {1'b1, 31'($urandom)};
    endfunction
    function automatic logic [5:0] f_other();
        logic [5:0] a = 6'($urandom);
        if (a == OWN) a = a ^ 6'h1;
        return a;
    endfunction

    task automatic add(logic [31:0] f);
        pkt.push_back({1'b0, f});
    endtask
    task automatic finish_pkt();
        pkt[pkt.size()-1][32] = 1'b1;
    endtask

    // expected outcome from the route rules
    task automatic model();
        bit deliver = 0;
        logic [3:0] m = '0;
        if (!(pkt[0][31] && pkt[0][30])) begin
            foreach (pkt[i]) exp_q[4].push_back(pkt[i]);
            return;
        end
        for (int i = 2; i < pkt.size(); i++) begin
            if (i - 2 >= MAXR) break;
            if (pkt[i][31]) break;
            if (pkt[i][9:4] == OWN) begin
                m = pkt[i][3:0] & EN;
                deliver = (m != 0);
                break;
            end
        end
        if (!deliver) exp_err++;
        else for (int p = 0; p < 4; p++)
            if (m[p]) foreach (pkt[i]) exp_q[p].push_back(pkt[i]);
    endtask

    task automatic send_pkt(bit gaps);
        foreach (pkt[i]) begin
            @(posedge clk); #1;
            if (gaps) begin
                int g = $urandom_range(0, 2);
                if (g > 0) begin
                    in_valid = 1'b0;
                    repeat (g) @(posedge clk);
                    #1;
                end
            end
            in_valid = 1'b1;
            in_data  = pkt[i][31:0];
            in_last  = pkt[i][32];
            @(negedge clk);
            while (!in_ready) begin
                @(posedge clk); #1;
                @(negedge clk);
            end
        end
        @(posedge clk); #1;
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic check_all(string req);
        repeat (80) @(posedge clk);
        for (int c = 0; c < 5; c++) begin
            int bad = -1;
            chk(got_q[c].size() == exp_q[c].size(), req, $sformatf("flit count ch%0d", c),
                got_q[c].size(), exp_q[c].size());
            if (got_q[c].size() == exp_q[c].size()) begin
                foreach (got_q[c][i]) if (bad < 0 && got_q[c][i] !== exp_q[c][i]) bad = i;
                if (bad >= 0)
                    chk(0, req, $sformatf("flit %0d ch%0d", bad, c), got_q[c][bad], exp_q[c][bad]);
            end
            got_q[c].delete();
            exp_q[c].delete();
        end
        chk(got_err == exp_err, req, "drop pulses", got_err, exp_err);
        got_err = 0;
        exp_err = 0;
    endtask

    task automatic run(string req, bit gaps);
        model();
        send_pkt(gaps);
        check_all(req);
    endtask

    task automatic gen_rand();
        int n, nd;
        pkt.delete();
        add(f_hdr($urandom_range(0, 4) != 0, $urandom_range(0, 4) != 0));
        if ($urandom_range(0, 7) != 0) add(32'($urandom));
        n = $urandom_range(0, MAXR + 1);
        for (int k = 0; k < n; k++)
            add(f_ent(($urandom_range(0, 2) == 0) ? OWN : f_other(), 4'($urandom)));
        if ($urandom_range(0, 1) != 0) add(f_end());
        nd = $urandom_range(0, 5);
        for (int k = 0; k < nd; k++) add(32'($urandom));
        finish_pkt();
    endtask

    // output readiness, changed just after each edge
    always @(posedge clk) begin
        #1;
        case (ready_mode)
            1: begin
                for (int p = 0; p < 4; p++) mc_ready[p] = ($urandom_range(0, 3) != 0);
                norm_ready = ($urandom_range(0, 3) != 0);
            end
            2: begin mc_ready = 4'b1101; norm_ready = 1'b1; end
            default: begin mc_ready = 4'hF; norm_ready = 1'b1; end
        endcase
    end

    always @(negedge clk) begin
        if (!rst) begin
            for (int p = 0; p < 4; p++)
                if (mc_valid[p] && mc_ready[p]) got_q[p].push_back({mc_last[p], mc_data[p]});
            if (norm_valid && norm_ready) got_q[4].push_back({norm_last, norm_data});
            if (drop_err) got_err++;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errs++;
            $display("FAIL R3 watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(mc_valid == 0 && !norm_valid && !rlb_bypass && !drop_err, "R10", "reset outputs",
            {mc_valid, norm_valid, rlb_bypass, drop_err}, 0);

        // R1: zero-latency pass of a non-test header
        @(posedge clk); #1;
        in_valid = 1'b1; in_data = f_hdr(0, 1); in_last = 1'b1;
        exp_q[4].push_back({1'b1, in_data});
        @(negedge clk);
        chk(norm_valid && !rlb_bypass && mc_valid == 0 && norm_data == in_data, "R1",
            "same-cycle pass", {norm_valid, rlb_bypass}, 2'b10);
        @(posedge clk); #1;
        in_valid = 1'b0; in_last = 1'b0;
        check_all("R1");

        // R2 and R9: single-flit multicast test header is taken and dropped
        @(posedge clk); #1;
        in_valid = 1'b1; in_data = f_hdr(1, 1); in_last = 1'b1;
        exp_err = 1;
        @(negedge clk);
        chk(rlb_bypass && !norm_valid && in_ready, "R2", "bypass on header",
            {rlb_bypass, norm_valid, in_ready}, 3'b101);
        @(posedge clk); #1;
        in_valid = 1'b0; in_last = 1'b0;
        check_all("R9");

        // R1: test packet without the multicast flag goes the normal way
        pkt.delete(); add(f_hdr(1, 0)); add(32'h5); add(f_ent(OWN, 4'hF)); finish_pkt();
        run("R1", 0);

        // R3: match on second entry, ports 0,1,3
        pkt.delete(); add(f_hdr(1, 1)); add(32'h2); add(f_ent(f_other(), 4'h4));
        add(f_ent(OWN, 4'b1011)); add(f_end()); add(32'hA1); add(32'hA2); add(32'hA3); finish_pkt();
        run("R3", 0);

        // R5: first matching entry wins
        pkt.delete(); add(f_hdr(1, 1)); add(32'h1); add(f_ent(OWN, 4'b0001));
        add(f_ent(OWN, 4'b1000)); add(32'hB0); finish_pkt();
        run("R5", 0);

        // R6: end marker with no match
        pkt.delete(); add(f_hdr(1, 1)); add(32'h3); add(f_ent(f_other(), 4'hF));
        add(f_ent(f_other(), 4'hF)); add(f_end()); add(f_ent(OWN, 4'hF)); add(32'hC0); finish_pkt();
        run("R6", 0);

        // R7: only a disabled port selected -> drop
        pkt.delete(); add(f_hdr(1, 1)); add(32'h1); add(f_ent(OWN, 4'b0100)); add(32'hD0); finish_pkt();
        run("R7", 0);
        // R7: disabled port masked out of a wider selection
        pkt.delete(); add(f_hdr(1, 1)); add(32'h1); add(f_ent(OWN, 4'b0110)); add(32'hD1); finish_pkt();
        run("R7", 0);

        // R8: match at the last slot the buffer allows
        pkt.delete(); add(f_hdr(1, 1)); add(32'h1);
        for (int k = 0; k < MAXR - 1; k++) add(f_ent(f_other(), 4'hF));
        add(f_ent(OWN, 4'b0001)); add(32'hE0); finish_pkt();
        run("R8", 0);
        // R8: one entry too many
        pkt.delete(); add(f_hdr(1, 1)); add(32'h1);
        for (int k = 0; k < MAXR; k++) add(f_ent(f_other(), 4'hF));
        add(f_ent(OWN, 4'b0001)); add(32'hE1); finish_pkt();
        run("R8", 0);

        // R9: packet ends inside the route list
        pkt.delete(); add(f_hdr(1, 1)); add(32'h1); add(f_ent(f_other(), 4'hF)); finish_pkt();
        run("R9", 0);
        // R9: packet ends at the control flit
        pkt.delete(); add(f_hdr(1, 1)); add(32'h1); finish_pkt();
        run("R9", 0);

        // R3: match on the final flit of the packet
        pkt.delete(); add(f_hdr(1, 1)); add(32'h7); add(f_ent(OWN, 4'b1001)); finish_pkt();
        run("R3", 0);

        // R4: one selected port held not ready stalls every copy
        pkt.delete(); add(f_hdr(1, 1)); add(32'h2); add(f_ent(OWN, 4'b1011));
        add(32'hF0); add(32'hF1); finish_pkt();
        model();
        ready_mode = 2;
        fork
            send_pkt(0);
            begin
                repeat (30) @(posedge clk);
                @(negedge clk);
                chk(got_q[0].size() == 0 && got_q[1].size() == 0 && got_q[3].size() == 0, "R4",
                    "copies while port1 blocked", got_q[0].size() + got_q[3].size(), 0);
                chk(!in_ready && mc_valid == 0, "R4", "input stalled", {in_ready, mc_valid}, 0);
                ready_mode = 0;
            end
        join
        check_all("R4");

        // random mix, R3 and drops
        ready_mode = 1;
        for (int t = 0; t < 40; t++) begin
            gen_rand();
            run("R3", 1);
        end
        ready_mode = 0;

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule